// File: doc/BRIEF.md
# Register-Controlled Serial Peripheral Master

This block is a serial peripheral interface master that a host drives through four word registers on a simple single-cycle bus. The registers are a control word, a status word, a transmit data word and a receive data word. The control word holds a device index that picks one of five active-low chip selects. It also holds a length field, where a value of N moves N+1 bits, from 1 to 32. Two start bits complete the control word. One starts a transmit-only transfer and the other starts a full-duplex transfer.

Once started, the engine sends the low N+1 bits of the transmit word most significant bit first. The serial clock is the system clock divided by a fixed even ratio. In full-duplex mode the bits arriving on the input line are packed right-justified into the receive word. Two status flags track the data: transmit-empty shows that the shift engine has consumed the transmit word, and receive-full shows that new receive data is waiting. A control write that arrives during a transfer is rejected with a bus error, and the register keeps its value.

Top module: `spim_top`

## Requirements
- R1: Register offsets on `bus_addr` are 0 control, 1 status, 2 transmit data, 3 receive data. The control word carries the full-duplex start in bit 0, the transmit start in bit 1, the length field in bits 6:2 and the device index in bits 9:7. Control bits 31:10 read as zero, and writable fields read back as written.
- R2: While a transfer runs, an index of 0 to 4 drives exactly that bit of `cs_n` low. Indices 5 to 7 drive no select, and at most one select is ever low.
- R3: A length field of N produces exactly N+1 serial clock pulses, so 0 gives 1 bit and 31 gives 32 bits.
- R4: A transfer with only bit 1 set leaves the receive register and receive-full unchanged. A transfer with bit 0 set captures the input bits.
- R5: `sclk` idles low and each half period lasts DIV system clocks. `mosi` presents bit N of the transmit word first, continues down to bit 0, and changes only as `sclk` falls. `miso` is sampled as `sclk` rises.
- R6: A control write during a transfer leaves the control register unchanged and drives `bus_err` high in that same bus cycle. No other access raises `bus_err`.
- R7: Status bit 1 (transmit-empty) resets to 1. A transmit data write clears it, and the end of a transfer sets it.
- R8: Status bit 0 (receive-full) resets to 0 and sets at the end of a full-duplex transfer. A read of the receive register clears it. The received bits sit right-justified in the receive register. Status bits 31:2 read as zero.
- R9: Both start bits clear by themselves when the transfer ends. Writing both start bits at once runs a full-duplex transfer.
- R10: After reset, all control fields are zero, every `cs_n` bit is high, and `sclk` and `mosi` are low.
- R11: The selected `cs_n` goes low in the cycle after the starting write. It stays low until the falling serial clock edge that ends the last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| bus_err | output | 1 | Error response for the current access |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NDEV | Active-low device selects |

## Verification
The bench runs transfers at several lengths: 1 bit, 5 bits, 8 bits, 12 bits and 32 bits. Comparing them separates a correct top-of-length alignment from one fixed at bit 31 or bit 0. It also exposes off-by-one errors in the bit counter. Write-only transfers are placed next to full-duplex transfers, and one transfer sets both start bits; together these separate mode decoding from simple flag setting. An undefined device index shows whether the select decoder lets a wrong select fall through. A control write in the middle of a transfer shows whether the busy guard protects the register and raises the error response.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int SPIM_DW = 32;
    localparam int LEN_W   = 5;
    localparam int IDX_W   = 3;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_STAT = 2'd1,
        A_TX   = 2'd2,
        A_RX   = 2'd3
    } addr_e;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [LEN_W-1:0] len;
        logic             tx_go;
        logic             dx_go;
    } ctrl_t;
endpackage

// File: rtl/spim_clkgen.sv
module spim_clkgen #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == CW'(DIV - 1));
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spim_shift.sv
module spim_shift
    import spim_pkg::*;
#(
    parameter int DW = SPIM_DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len_i,
    input  logic [DW-1:0]    tx_i,
    input  logic             tick,
    input  logic             miso,
    output logic             active,
    output logic             sclk,
    output logic             mosi,
    output logic             done,
    output logic [DW-1:0]    rx_o
);
    typedef struct packed {
        logic             active;
        logic             sclk;
        logic [DW-1:0]    sh;
        logic [DW-1:0]    acc;
        logic [LEN_W-1:0] bits;
        logic [LEN_W-1:0] last;
    } eng_t;

    eng_t s_d, s_q;
    logic [LEN_W-1:0] shamt;

    always_comb begin
        s_d   = s_q;
        shamt = LEN_W'(DW - 1) - len_i;
        done  = s_q.active && tick && s_q.sclk && (s_q.bits == s_q.last);
        if (start) begin
            s_d.active = 1'b1;
            s_d.sclk   = 1'b0;
            s_d.sh     = tx_i << shamt;
            s_d.acc    = '0;
            s_d.bits   = '0;
            s_d.last   = len_i;
        end else if (s_q.active && tick) begin
            if (!s_q.sclk) begin
                s_d.sclk = 1'b1;
                s_d.acc  = {s_q.acc[DW-2:0], miso};
            end else begin
                s_d.sclk = 1'b0;
                if (done) begin
                    s_d.active = 1'b0;
                end else begin
                    s_d.bits = s_q.bits + 1'b1;
                    s_d.sh   = {s_q.sh[DW-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active = s_q.active;
    assign sclk   = s_q.sclk;
    assign mosi   = s_q.active & s_q.sh[DW-1];
    assign rx_o   = s_q.acc;

    // R5
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.active |-> !s_q.sclk);
    // R3
    bit_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.active |-> (s_q.bits <= s_q.last));
    // R5
    mosi_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && s_q.sclk && !tick) |=> $stable(mosi));
endmodule

// File: rtl/spim_csdec.sv
module spim_csdec #(
    parameter int NDEV = 5,
    parameter int IW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [IW-1:0] idx,
    output logic [NDEV-1:0] cs_n
);
    generate
        for (genvar i = 0; i < NDEV; i++) begin : g_sel
            assign cs_n[i] = !(en && (idx == IW'(i)));
        end
    endgenerate

    // R2
    single_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    // R11
    idle_no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (&cs_n));
endmodule

// File: rtl/spim_top.sv
module spim_top
    import spim_pkg::*;
#(
    parameter int NDEV = 5,
    parameter int DIV  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [1:0]      bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    output logic            bus_err,
    output logic            sclk,
    output logic            mosi,
    input  logic            miso,
    output logic [NDEV-1:0] cs_n
);
    localparam int DW     = SPIM_DW;
    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t         ctrl;
        logic [DW-1:0] tx;
        logic [DW-1:0] rx;
        logic          tx_empty;
        logic          rx_full;
    } regs_t;

    regs_t r_d, r_q;

    logic          wr_acc, rd_acc, busy, start;
    logic          tick, eng_active, eng_done;
    logic [DW-1:0] eng_rx;
    addr_e         addr;

    always_comb begin
        addr   = addr_e'(bus_addr);
        wr_acc = bus_sel && bus_wr;
        rd_acc = bus_sel && !bus_wr;
        busy   = r_q.ctrl.tx_go || r_q.ctrl.dx_go;
        start  = wr_acc && (addr == A_CTRL) && !busy && (bus_wdata[1] || bus_wdata[0]);

        r_d = r_q;
        if (eng_done) begin
            r_d.ctrl.tx_go = 1'b0;
            r_d.ctrl.dx_go = 1'b0;
            r_d.tx_empty   = 1'b1;
            if (r_q.ctrl.dx_go) begin
                r_d.rx      = eng_rx;
                r_d.rx_full = 1'b1;
            end
        end
        if (wr_acc) begin
            case (addr)
                A_CTRL: if (!busy) r_d.ctrl = ctrl_t'(bus_wdata[CTRL_W-1:0]);
                A_TX: begin
                    r_d.tx       = bus_wdata[DW-1:0];
                    r_d.tx_empty = 1'b0;
                end
                default: ;
            endcase
        end
        if (rd_acc && (addr == A_RX)) r_d.rx_full = 1'b0;

        bus_err = wr_acc && (addr == A_CTRL) && busy;
        case (addr)
            A_CTRL:  bus_rdata = {{(32-CTRL_W){1'b0}}, r_q.ctrl};
            A_STAT:  bus_rdata = {30'b0, r_q.tx_empty, r_q.rx_full};
            A_TX:    bus_rdata = r_q.tx;
            default: bus_rdata = r_q.rx;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.tx_empty <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    spim_clkgen #(.DIV(DIV)) u_clk (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (eng_active),
        .tick (tick)
    );

    spim_shift #(.DW(DW)) u_eng (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .len_i (bus_wdata[6:2]),
        .tx_i  (r_q.tx),
        .tick  (tick),
        .miso  (miso),
        .active(eng_active),
        .sclk  (sclk),
        .mosi  (mosi),
        .done  (eng_done),
        .rx_o  (eng_rx)
    );

    spim_csdec #(.NDEV(NDEV), .IW(IDX_W)) u_cs (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (eng_active),
        .idx  (r_q.ctrl.idx),
        .cs_n (cs_n)
    );

    // R6
    ctrl_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && !eng_done) |=> $stable(r_q.ctrl));
    // R9
    go_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> (!r_q.ctrl.tx_go && !r_q.ctrl.dx_go));
    // R7
    tx_empty_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && addr == A_TX) |=> !r_q.tx_empty);
    // R8
    rx_full_duplex_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.rx_full) |-> $past(r_q.ctrl.dx_go));
    // R11
    busy_matches_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy == eng_active);
endmodule

// File: tb/spim_top_test.sv
module spim_top_test;
    localparam int PERIOD = 10;
    localparam int DIV    = 2;
    localparam int NDEV   = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            bus_err, sclk, mosi;
    logic            miso = 1'b0;
    logic [NDEV-1:0] cs_n;

    int n_cmp = 0, n_bad = 0;
    bit done_flag = 0;

    spim_top #(.NDEV(NDEV), .DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    always #(PERIOD/2) clk = ~clk;

    // behavioural reference model
    int          m_idx, m_len, m_k, m_bits;
    bit          m_txg, m_dxg, m_busy, m_te, m_rf, m_live;
    logic [31:0] m_tx, m_rx, m_txs, m_acc, m_slave;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_idx = 0; m_len = 0; m_txg = 0; m_dxg = 0; m_busy = 0; m_k = 0;
            m_te = 1; m_rf = 0; m_tx = 0; m_rx = 0; m_txs = 0; m_acc = 0;
            m_live = 1;
        end else begin
            bit was_busy;
            was_busy = m_busy;
            if (m_busy) begin
                m_k++;
                if (m_k % DIV == 0) begin
                    int h;
                    h = m_k / DIV;
                    if (h % 2 == 1) m_acc = (m_acc << 1) | {31'b0, miso};
                    else if (h == 2 * m_len) begin
                        m_busy = 0; m_te = 1;
                        if (m_dxg) begin m_rx = m_acc; m_rf = 1; end
                        m_txg = 0; m_dxg = 0;
                    end
                end
            end
            if (bus_sel && bus_wr) begin
                if (bus_addr == 2'd0 && !was_busy) begin
                    m_idx = int'(bus_wdata[9:7]);
                    m_bits = int'(bus_wdata[6:2]);
                    m_txg = bus_wdata[1]; m_dxg = bus_wdata[0];
                    if (bus_wdata[1] || bus_wdata[0]) begin
                        m_busy = 1; m_k = 0; m_acc = 0;
                        m_len = m_bits + 1; m_txs = m_tx;
                    end
                end else if (bus_addr == 2'd2) begin
                    m_tx = bus_wdata; m_te = 0;
                end
            end
            if (bus_sel && !bus_wr && bus_addr == 2'd3) m_rf = 0;
        end
    end

    // slave side drives miso away from the rising edge
    always @(negedge clk) begin
        if (m_live && m_busy) miso <= m_slave[m_len - 1 - (m_k / DIV) / 2];
        else                  miso <= 1'b0;
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n && m_live) begin
            logic [NDEV-1:0] ecs;
            logic [31:0]     erd;
            int b;
            b = (m_k / DIV) / 2;
            ecs = '1;
            if (m_busy && m_idx < NDEV) ecs[m_idx] = 1'b0;
            chk("R2/R11 cs_n", 32'(cs_n), 32'(ecs));
            chk("R5/R3 sclk", 32'(sclk), 32'(m_busy && ((m_k / DIV) % 2 == 1)));
            chk("R5 mosi", 32'(mosi), m_busy ? 32'(m_txs[m_len - 1 - b]) : 32'd0);
            chk("R6 bus_err", 32'(bus_err), 32'(bus_sel && bus_wr && bus_addr == 2'd0 && m_busy));
            if (bus_sel && !bus_wr) begin
                case (bus_addr)
                    2'd0: erd = {22'b0, 3'(m_idx), 5'(m_bits), m_txg, m_dxg};
                    2'd1: erd = {30'b0, m_te, m_rf};
                    2'd2: erd = m_tx;
                    default: erd = m_rx;
                endcase
                chk("R1/R8 model rdata", bus_rdata, erd);
            end
        end
    end

    task automatic bus_write(logic [1:0] a, logic [31:0] d, logic exp_err, string req);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        chk(req, 32'(bus_err), 32'(exp_err));
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(logic [1:0] a, logic [31:0] exp, string req);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        chk(req, bus_rdata, exp);
        @(posedge clk); #1;
        bus_sel = 0;
    endtask

    task automatic wait_idle();
        while (m_busy) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        m_live = 0; m_slave = 0; m_busy = 0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        // R10 reset state
        @(negedge clk);
        chk("R10 cs_n reset", 32'(cs_n), 32'h1F);
        chk("R10 sclk/mosi reset", {30'b0, sclk, mosi}, 32'd0);
        bus_read(2'd0, 32'd0, "R10 ctrl reset");
        bus_read(2'd1, 32'd2, "R7/R8 status reset");

        // R4 write-only, 8 bits, device 0
        bus_write(2'd2, 32'h0000_00A5, 0, "R7 tx write");
        bus_read(2'd1, 32'd0, "R7 tx_empty cleared");
        m_slave = 32'hFFFF_FFFF;
        bus_write(2'd0, (32'd0 << 7) | (32'd7 << 2) | 32'd2, 0, "R4 start tx-only");
        wait_idle();
        bus_read(2'd1, 32'd2, "R4 rx_full untouched, R7 empty set");
        bus_read(2'd3, 32'd0, "R4 rx unchanged");

        // full duplex, 32 bits, device 2, with a rejected control write
        bus_write(2'd2, 32'h1234_5678, 0, "R7 tx write");
        m_slave = 32'hCAFE_F00D;
        bus_write(2'd0, (32'd2 << 7) | (32'd31 << 2) | 32'd1, 0, "R3 start 32b");
        chk("R11 cs low after start", 32'(cs_n), 32'h1B);
        bus_write(2'd0, 32'h0000_03FF, 1, "R6 error on busy write");
        bus_read(2'd0, (32'd2 << 7) | (32'd31 << 2) | 32'd1, "R6 ctrl unchanged");
        wait_idle();
        bus_read(2'd1, 32'd3, "R8 rx_full set");
        bus_read(2'd3, 32'hCAFE_F00D, "R8 rx 32b");
        bus_read(2'd1, 32'd2, "R8 rx_full cleared");
        bus_read(2'd0, (32'd2 << 7) | (32'd31 << 2), "R9 go cleared");

        // single bit, device 4
        bus_write(2'd2, 32'h0000_0001, 0, "R7 tx write");
        m_slave = 32'h0000_0001;
        bus_write(2'd0, (32'd4 << 7) | (32'd0 << 2) | 32'd1, 0, "R3 start 1b");
        chk("R2 device 4", 32'(cs_n), 32'h0F);
        wait_idle();
        bus_read(2'd3, 32'h0000_0001, "R3 rx 1b");

        // undefined index 5, 5 bits
        bus_write(2'd2, 32'h0000_000A, 0, "R7 tx write");
        m_slave = 32'h0000_0015;
        bus_write(2'd0, (32'd5 << 7) | (32'd4 << 2) | 32'd1, 0, "R2 start idx5");
        chk("R2 no select idx5", 32'(cs_n), 32'h1F);
        wait_idle();
        bus_read(2'd3, 32'h0000_0015, "R8 rx 5b right-justified");

        // both start bits -> full duplex, 12 bits, device 1
        bus_write(2'd2, 32'h0000_0F0F, 0, "R7 tx write");
        m_slave = 32'h0000_0ABC;
        bus_write(2'd0, (32'd1 << 7) | (32'd11 << 2) | 32'd3, 0, "R9 start both");
        chk("R2 device 1", 32'(cs_n), 32'h1D);
        wait_idle();
        bus_read(2'd3, 32'h0000_0ABC, "R9 both bits captured");
        bus_read(2'd0, (32'd1 << 7) | (32'd11 << 2), "R9 both cleared");
        bus_write(2'd2, 32'h5555_0000, 0, "R7 tx write");
        bus_read(2'd1, 32'd0, "R7 tx_empty clear after write");

        // reserved control bits
        bus_write(2'd0, 32'hFFFF_FC00 | (32'd3 << 7) | (32'd2 << 2), 0, "R1 ctrl write");
        bus_read(2'd0, (32'd3 << 7) | (32'd2 << 2), "R1 reserved zero");
        bus_read(2'd2, 32'h5555_0000, "R1 tx readback");
        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule